// File: doc/BRIEF.md
# Block-Sized DMA Request Pacer

This block paces the DMA request line that feeds a hashing engine with no input FIFO. Every word the DMA writes goes straight into the engine's message schedule. Because of this, the request is raised only while the engine says it can take data. Each request burst covers exactly one 512-bit message block. When the block has been delivered, the request is withdrawn until the engine has been busy and has become ready again.

The number of bus writes in a burst follows the configured transfer width. The width is captured when the burst begins, so it must be programmed before the DMA channel is triggered. A down-counter is loaded with the burst length when a burst opens, and it steps down on every accepted write.

The controller has three named states:
- `S_IDLE`: the request is low, waiting for the engine to be ready.
- `S_REQ`: the request is high and writes are counted.
- `S_HOLD`: the block is complete, and the controller waits for the engine to go busy.

The state changes are:
- `S_IDLE`→`S_REQ` when the engine is ready.
- `S_REQ`→`S_HOLD` on the write that takes the count to zero.
- `S_HOLD`→`S_IDLE` when the engine reports not-ready.
- A start pulse forces any state to `S_IDLE` and clears the counter.

Top module: `blk_dma_pacer`

## Requirements
- R1: While reset is asserted and after its release, `req_o` is low.
- R2: A burst opens only from `S_IDLE` with `eng_ready_i` high. `req_o` rises on the clock edge after that cycle. While `eng_ready_i` is low in `S_IDLE`, `req_o` stays low, so no write reaches a busy engine.
- R3: With `xfer_size_i` = 2'b10 (32-bit), a burst lasts exactly 16 accepted writes. `req_o` falls on the edge that accepts the 16th write.
- R4: With `xfer_size_i` = 2'b01 (16-bit), a burst lasts exactly 32 accepted writes.
- R5: With `xfer_size_i` = 2'b00 (8-bit), a burst lasts exactly 64 accepted writes.
- R6: The unused code `xfer_size_i` = 2'b11 is treated as 32-bit, giving 16 writes.
- R7: After a burst ends, `req_o` stays low while `eng_ready_i` stays high. A new burst needs `eng_ready_i` to be seen low and then high again.
- R8: Write strobes that arrive while `req_o` is low have no effect. The next burst still has its full length.
- R9: A `start_i` pulse returns the block to `S_IDLE` with the counter cleared, even when it coincides with a write. `req_o` is low after that edge, and the next burst has its full length.
- R10: The burst length is captured when `req_o` rises. Changing `xfer_size_i` during a burst does not alter that burst's length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle pulse that abandons any burst and clears the counter |
| eng_ready_i | input | 1 | High while the hashing engine can accept message data |
| xfer_size_i | input | 2 | Transfer width: 00 byte, 01 halfword, 10 word, 11 word |
| wr_done_i | input | 1 | One-cycle strobe per completed bus write into the engine |
| req_o | output | 1 | DMA request level |

## Verification
Directed bursts are run at each transfer-width code with a write on every cycle. They separate the three burst lengths and show that the reserved code falls back to word length. The ready line is held high after a burst, and strobes are issued while the request is low. This separates correct re-arm behaviour from a pacer that re-requests at once or counts stray writes. A start pulse that lands on a write, and a width change in mid-burst, tell apart a counter that is cleared and captured correctly from one that reloads late or decrements on the start edge. Constrained-random rounds then pair a gappy DMA model with an engine that goes busy for random spans. They check, for every width, that blocks keep completing and that no write ever lands while the engine is busy.

// File: rtl/pacer_pkg.sv
package pacer_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } xfer_size_e;

    typedef enum logic [1:0] {
        S_IDLE = 2'b00,
        S_REQ  = 2'b01,
        S_HOLD = 2'b10
    } pacer_state_e;

    // log2 of the bytes moved by one write for a given size code
    function automatic int unsigned size_shift(input logic [1:0] code);
        case (code)
            SZ_BYTE: size_shift = 0;
            SZ_HALF: size_shift = 1;
            default: size_shift = 2;
        endcase
    endfunction

endpackage

// File: rtl/pacer_len_dec.sv
module pacer_len_dec
    import pacer_pkg::*;
#(
    parameter int BLOCK_BYTES = 64,
    parameter int CNT_W       = $clog2(BLOCK_BYTES) + 1
) (
    input  logic [1:0]       size_i,
    output logic [CNT_W-1:0] len_o
);
    localparam int N_CODES = 4;

    logic [CNT_W-1:0] len_tbl [N_CODES];

    for (genvar g = 0; g < N_CODES; g++) begin : g_tbl
        localparam logic [1:0] CODE = g[1:0];
        assign len_tbl[g] = CNT_W'(BLOCK_BYTES >> size_shift(CODE));
    end

    assign len_o = len_tbl[size_i];

endmodule

// File: rtl/pacer_cnt.sv
module pacer_cnt #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             dec_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             last_o
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (dec_i && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign cnt_o  = cnt_q;
    assign last_o = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/pacer_fsm.sv
module pacer_fsm
    import pacer_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic         eng_ready_i,
    input  logic         wr_i,
    input  logic         last_i,
    output pacer_state_e state_o,
    output logic         clr_o,
    output logic         load_o,
    output logic         dec_o,
    output logic         req_o
);
    pacer_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (start_i) begin
            state_d = S_IDLE;
        end else begin
            unique case (state_q)
                S_IDLE:  if (eng_ready_i)      state_d = S_REQ;
                S_REQ:   if (wr_i && last_i)   state_d = S_HOLD;
                S_HOLD:  if (!eng_ready_i)     state_d = S_IDLE;
                default:                       state_d = S_IDLE;
            endcase
        end
    end

    always_comb begin
        clr_o  = start_i;
        load_o = 1'b0;
        dec_o  = 1'b0;
        req_o  = 1'b0;
        unique case (state_q)
            S_IDLE:  load_o = eng_ready_i && !start_i;
            S_REQ:   begin
                req_o = 1'b1;
                dec_o = wr_i && !start_i;
            end
            S_HOLD:  ;
            default: ;
        endcase
    end

    assign state_o = state_q;

    p_idle_waits_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && !eng_ready_i) |=> !req_o);

    p_hold_keeps_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_HOLD && eng_ready_i && !start_i) |=> (state_q == S_HOLD && !req_o));

    p_start_aborts_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (state_q == S_IDLE && !req_o));

endmodule

// File: rtl/blk_dma_pacer.sv
module blk_dma_pacer
    import pacer_pkg::*;
#(
    parameter int BLOCK_BITS = 512
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       eng_ready_i,
    input  logic [1:0] xfer_size_i,
    input  logic       wr_done_i,
    output logic       req_o
);
    localparam int BLOCK_BYTES = BLOCK_BITS / 8;
    localparam int CNT_W       = $clog2(BLOCK_BYTES) + 1;

    logic [CNT_W-1:0] burst_len;
    logic [CNT_W-1:0] cnt;
    logic             last, clr, load, dec;
    pacer_state_e     state;

    pacer_len_dec #(.BLOCK_BYTES(BLOCK_BYTES), .CNT_W(CNT_W)) u_len (
        .size_i (xfer_size_i),
        .len_o  (burst_len)
    );

    pacer_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (clr),
        .load_i     (load),
        .load_val_i (burst_len),
        .dec_i      (dec),
        .cnt_o      (cnt),
        .last_o     (last)
    );

    pacer_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .eng_ready_i (eng_ready_i),
        .wr_i        (wr_done_i),
        .last_i      (last),
        .state_o     (state),
        .clr_o       (clr),
        .load_o      (load),
        .dec_o       (dec),
        .req_o       (req_o)
    );

    // R3 R4 R5 R6 R10: the count at burst opening is the length decoded one edge earlier
    p_len_loaded_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_o) |-> (cnt == $past(burst_len)));

    p_no_underflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |-> (cnt != '0));

    p_stray_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_o && wr_done_i && !start_i && !eng_ready_i) |=> $stable(cnt));

    p_start_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (cnt == '0));

    p_state_known_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({state == S_REQ, state == S_HOLD}));

endmodule

// File: tb/test_blk_dma_pacer.sv
`timescale 1ns/1ps
module test_blk_dma_pacer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [1:0] xfer_size_i = 2'b10;
    logic       req_o;
    logic       wr_dir = 1'b0;
    logic       wr_dma = 1'b0;
    logic       wr_done_i;
    logic       eng_ready_i;

    logic       man_en = 1'b1;
    logic       man_val = 1'b0;
    logic       dma_en = 1'b0;
    logic       eng_rdy_q;
    int         eng_bytes, eng_busy, blocks, busy_hits;
    int         n_tests = 0, n_fail = 0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    assign wr_done_i   = wr_dir | wr_dma;
    assign eng_ready_i = man_en ? man_val : eng_rdy_q;

    blk_dma_pacer i_blk_dma_pacer (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .eng_ready_i (eng_ready_i),
        .xfer_size_i (xfer_size_i),
        .wr_done_i   (wr_done_i),
        .req_o       (req_o)
    );

    function automatic int bytes_per(input logic [1:0] s);
        return (s == 2'b00) ? 1 : (s == 2'b01) ? 2 : 4;
    endfunction

    function automatic int exp_len(input logic [1:0] s);
        return 64 / bytes_per(s);
    endfunction

    // engine model: goes busy for a random span after each 64-byte block
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_rdy_q <= 1'b1; eng_bytes <= 0; eng_busy <= 0;
            blocks <= 0; busy_hits <= 0;
        end else if (man_en) begin
            eng_rdy_q <= 1'b1;
        end else if (start_i) begin
            eng_rdy_q <= 1'b1; eng_bytes <= 0; eng_busy <= 0;
        end else if (!eng_rdy_q) begin
            if (wr_done_i) busy_hits <= busy_hits + 1;
            if (eng_busy == 0) eng_rdy_q <= 1'b1;
            else               eng_busy  <= eng_busy - 1;
        end else if (wr_done_i) begin
            if (eng_bytes + bytes_per(xfer_size_i) >= 64) begin
                eng_bytes <= 0; eng_rdy_q <= 1'b0;
                eng_busy  <= 2 + int'($urandom % 39);
                blocks    <= blocks + 1;
            end else begin
                eng_bytes <= eng_bytes + bytes_per(xfer_size_i);
            end
        end
    end

    // DMA model: writes only while the request is high, with random gaps
    always @(negedge clk) wr_dma <= dma_en && req_o && ($urandom % 4 != 0);

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic measure(output int n);
        n = 0;
        while (req_o && n < 200) begin
            wr_dir = 1'b1; n++;
            @(negedge clk);
        end
        wr_dir = 1'b0;
    endtask

    task automatic rearm(input string req);
        man_val = 1'b0; @(negedge clk);
        man_val = 1'b1; @(negedge clk);
        check(req, int'(req_o), 1);
    endtask

    initial begin
        int n;
        void'($urandom(32'h5EED_0A17));
        repeat (3) @(negedge clk);
        check("R1 req in reset", int'(req_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 req after reset", int'(req_o), 0);
        repeat (5) @(negedge clk);
        check("R2 no req while busy", int'(req_o), 0);

        xfer_size_i = 2'b10; man_val = 1'b1;
        @(negedge clk);
        check("R2 req one edge after ready", int'(req_o), 1);
        measure(n); check("R3 word burst", n, 16);

        repeat (10) @(negedge clk);
        check("R7 low while ready stays high", int'(req_o), 0);
        wr_dir = 1'b1; repeat (5) @(negedge clk); wr_dir = 1'b0;
        check("R8 stray writes no req", int'(req_o), 0);

        xfer_size_i = 2'b01; rearm("R7 rearm after busy");
        measure(n); check("R4 halfword burst (R8 full after stray)", n, 32);
        xfer_size_i = 2'b00; rearm("R7 rearm");
        measure(n); check("R5 byte burst", n, 64);
        xfer_size_i = 2'b11; rearm("R7 rearm");
        measure(n); check("R6 reserved code as word", n, 16);

        xfer_size_i = 2'b00; rearm("R7 rearm");
        xfer_size_i = 2'b10;
        measure(n); check("R10 size change mid-burst", n, 64);

        rearm("R7 rearm");
        wr_dir = 1'b1; repeat (5) @(negedge clk);
        start_i = 1'b1; @(negedge clk);
        start_i = 1'b0; wr_dir = 1'b0;
        check("R9 req low after start", int'(req_o), 0);
        @(negedge clk);
        check("R9 reopen after start", int'(req_o), 1);
        measure(n); check("R9 full burst after start", n, 16);

        // random rounds with engine and DMA models
        man_en = 1'b0; dma_en = 1'b1;
        for (int r = 0; r < 12; r++) begin
            int b0, t;
            xfer_size_i = 2'($urandom % 4);
            start_i = 1'b1; @(negedge clk); start_i = 1'b0;
            b0 = blocks; t = 0;
            while (blocks < b0 + 3 && t < 4000) begin @(negedge clk); t++; end
            check($sformatf("R3 R4 R5 R6 blocks size=%0d", xfer_size_i), blocks - b0, 3);
        end
        dma_en = 1'b0; repeat (4) @(negedge clk);
        check("R2 writes while engine busy", busy_hits, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(150000 * 5);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule